// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit sits beside a free-running timer counter and records the counter value at the moments an external pin changes. The pin passes through a multi-flop synchronizer. The unit then compares each synchronized sample with the one before it to find rising edges, falling edges or both, as the mode input selects.

Each arming allows up to two captures. The first qualifying edge loads capture slot A and the second loads slot B. Any edge after that is dropped until the unit is armed again. There are two ways to re-arm: a clear strobe from the status logic, or moving the mode away from "off". The capture-on-second input chooses whether the one-cycle event strobe, which goes to the interrupt status logic, fires on the first capture or on the second.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset both capture registers read 0 and the event strobe is low.
- R2: Mode code 1 captures on a 0-to-1 transition of the synchronized pin only.
- R3: Mode code 2 captures on a 1-to-0 transition of the synchronized pin only.
- R4: Mode code 3 captures on every transition of the synchronized pin.
- R5: Mode code 0 performs no capture and raises no event.
- R6: No capture and no event occur while the direction input is 0 (pin configured as output); captures need it at 1.
- R7: The first capture after arming loads slot A and the second loads slot B. The stored value is the count input in the cycle the edge is detected, which is SYNC_STAGES cycles after the pin change is first sampled. The result is visible one clock later.
- R8: Once two captures are stored, further edges leave both slots unchanged and raise no event until re-armed.
- R9: With the capture-on-second input at 0, the event fires on the first capture only. With it at 1, the event fires on the second capture only.
- R10: A one-cycle clear strobe re-arms the unit. Slot contents are kept until overwritten, and the next capture goes to slot A. A re-arm in the same cycle as an edge drops that edge.
- R11: Moving the mode from code 0 to any other code re-arms the unit. Moving between two non-zero codes does not.
- R12: The event strobe is one clock wide for each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | External pin, asynchronous |
| count_i | input | CNT_W | Live timer counter value |
| cap_mode_i | input | 2 | 0 off, 1 rising, 2 falling, 3 both |
| pin_in_i | input | 1 | 1 when the pin is an input |
| cap_second_i | input | 1 | 1 raises the event on the second capture |
| cap_clr_i | input | 1 | Re-arm strobe from a status write |
| cap_a_o | output | CNT_W | First capture slot |
| cap_b_o | output | CNT_W | Second capture slot |
| cap_evt_o | output | 1 | One-cycle capture event |

## Verification
The bench uses CNT_W = 8 and SYNC_STAGES = 3. With an 8-bit counter, the count the bench drives wraps every 256 cycles, so the run captures values on both sides of the wrap. Three synchronizer stages exercise the generated chain beyond its minimum depth, and every expected capture value is derived from that depth. The bench steps through all four modes, both strobe choices, and both re-arm paths, and it checks that a move between two non-zero modes keeps the capture count.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_BOTH = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sync_i,
  input  cap_mode_e mode_i,
  output logic      hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_i;

  always_comb begin
    unique case (mode_i)
      CAP_RISE: hit_o = sync_i & ~prev_q;
      CAP_FALL: hit_o = ~sync_i & prev_q;
      CAP_BOTH: hit_o = sync_i ^ prev_q;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             armed_i,
  input  logic             rearm_i,
  input  logic             second_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             evt_o
);
  localparam int NSLOT = 2;
  localparam int CW    = $clog2(NSLOT + 1);

  logic [CW-1:0]    cnt_q;
  logic [CNT_W-1:0] cap_a_q, cap_b_q;
  logic             evt_q;
  logic             take;

  // re-arm wins over a coincident edge
  assign take = hit_i & armed_i & ~rearm_i & (cnt_q < CW'(NSLOT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cap_a_q <= '0;
      cap_b_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= take & (cnt_q[0] == second_i);
      if (rearm_i) begin
        cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0) cap_a_q <= count_i;
        else             cap_b_q <= count_i;
      end
    end
  end

  assign cap_a_o = cap_a_q;
  assign cap_b_o = cap_b_q;
  assign evt_o   = evt_q;

  a_r10_rearm_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> cnt_q == '0);
  a_r8_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(NSLOT)) |=> ($stable(cap_a_q) && $stable(cap_b_q) && !evt_q));
  a_r9_evt_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> ($past(cnt_q) == CW'($past(second_i))));
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NSLOT));
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import cap_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [1:0]       cap_mode_i,
  input  logic             pin_in_i,
  input  logic             cap_second_i,
  input  logic             cap_clr_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic             cap_evt_o
);
  cap_mode_e mode, mode_q;
  logic      sync, hit, rearm;

  assign mode = cap_mode_e'(cap_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mode_q <= CAP_OFF;
    else         mode_q <= mode;

  assign rearm = cap_clr_i | ((mode_q == CAP_OFF) & (mode != CAP_OFF));

  cap_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (sync)
  );

  cap_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync),
    .mode_i (mode),
    .hit_o  (hit)
  );

  cap_store #(.CNT_W(CNT_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .armed_i  (pin_in_i),
    .rearm_i  (rearm),
    .second_i (cap_second_i),
    .count_i  (count_i),
    .cap_a_o  (cap_a_o),
    .cap_b_o  (cap_b_o),
    .evt_o    (cap_evt_o)
  );

  a_r5_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CAP_OFF) |=> ($stable(cap_a_o) && $stable(cap_b_o) && !cap_evt_o));
  a_r6_output_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_in_i |=> ($stable(cap_a_o) && $stable(cap_b_o) && !cap_evt_o));
  a_r2_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CAP_RISE && hit) |-> sync);
  a_r3_fall_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CAP_FALL && hit) |-> !sync);
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  localparam int CW = 8;
  localparam int SS = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pin = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          dir = 1'b0, sec = 1'b0, clr = 1'b0;
  logic [CW-1:0] cap_a, cap_b;
  logic          evt;
  int            cyc = 0;
  logic [CW-1:0] count;

  always #4 clk = ~clk;
  assign count = cyc[CW-1:0];

  edge_capture_unit #(.CNT_W(CW), .SYNC_STAGES(SS)) i_edge_capture_unit (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .count_i(count),
    .cap_mode_i(mode), .pin_in_i(dir), .cap_second_i(sec), .cap_clr_i(clr),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .cap_evt_o(evt)
  );

  typedef struct {
    int            due;
    logic [CW-1:0] a;
    logic [CW-1:0] b;
    logic          e;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [1:0]    mode_m = 2'd0;
  logic          pin_m = 1'b0, dir_m = 1'b0, sec_m = 1'b0;
  int            ncap = 0;
  logic [CW-1:0] ea = '0, eb = '0;

  task automatic chk(string tag, logic [CW-1:0] a, logic [CW-1:0] b, logic e);
    checks++;
    if (cap_a !== a || cap_b !== b || evt !== e) begin
      fails++;
      $display("FAIL %s: a=%0h b=%0h evt=%0b expected a=%0h b=%0h evt=%0b",
               tag, cap_a, cap_b, evt, a, b, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  // monitor: pops scoreboard items when due
  initial forever begin
    @(negedge clk);
    cyc++;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      chk(it.tag, it.a, it.b, it.e);
    end
  end

  task automatic drive_pin(logic v, string tag);
    logic          hit;
    logic          e;
    logic [CW-1:0] cv;
    hit = dir_m && ((mode_m == 2'd1 && !pin_m && v) ||
                    (mode_m == 2'd2 && pin_m && !v) ||
                    (mode_m == 2'd3 && pin_m != v));
    cv = CW'(cyc + SS);
    e  = 1'b0;
    if (hit && ncap < 2) begin
      if (ncap == 0) ea = cv;
      else           eb = cv;
      e = (ncap == int'(sec_m));
      ncap++;
    end
    pin   = v;
    pin_m = v;
    q.push_back('{due: cyc + SS + 1, a: ea, b: eb, e: e, tag: tag});
    q.push_back('{due: cyc + SS + 2, a: ea, b: eb, e: 1'b0, tag: {tag, " R12 single"}});
    repeat (SS + 3) step();
  endtask

  task automatic set_cfg(logic [1:0] m, logic d, logic s);
    if (mode_m == 2'd0 && m != 2'd0) ncap = 0;
    mode = m; dir = d; sec = s;
    mode_m = m; dir_m = d; sec_m = s;
    step(); step();
  endtask

  task automatic do_clear();
    clr = 1'b1;
    ncap = 0;
    step();
    clr = 1'b0;
    step();
  endtask

  initial begin
    step();
    chk("R1 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    step(); step();
    chk("R1 after reset", '0, '0, 1'b0);

    set_cfg(2'd1, 1'b1, 1'b0);
    drive_pin(1'b1, "R2 R7 first rise to A, R9 evt");
    drive_pin(1'b0, "R2 fall ignored");
    drive_pin(1'b1, "R7 second rise to B, R9 no evt");
    drive_pin(1'b0, "R2 fall ignored");
    drive_pin(1'b1, "R8 third edge dropped");
    do_clear();
    chk("R10 clear keeps slots", ea, eb, 1'b0);
    drive_pin(1'b0, "R2 fall ignored after clear");
    drive_pin(1'b1, "R10 rearmed to A");

    set_cfg(2'd2, 1'b1, 1'b0);
    drive_pin(1'b0, "R3 R11 fall to B, no rearm");
    drive_pin(1'b1, "R3 rise ignored");

    set_cfg(2'd0, 1'b1, 1'b1);
    drive_pin(1'b0, "R5 off no capture");
    drive_pin(1'b1, "R5 off no capture");
    set_cfg(2'd3, 1'b1, 1'b1);
    drive_pin(1'b0, "R4 R11 both to A, R9 no evt");
    drive_pin(1'b1, "R4 both to B, R9 evt on second");
    drive_pin(1'b0, "R8 full ignored");

    set_cfg(2'd0, 1'b0, 1'b1);
    set_cfg(2'd3, 1'b0, 1'b1);
    drive_pin(1'b1, "R6 output dir ignored");
    drive_pin(1'b0, "R6 output dir ignored");
    set_cfg(2'd3, 1'b1, 1'b0);
    drive_pin(1'b1, "R6 R7 input dir to A, R9 evt");
    repeat (200) step();
    drive_pin(1'b0, "R7 wrapped count to B");

    repeat (4) step();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule